// File: doc/BRIEF.md
# Alternate Byte Peripheral Transfer Unit

This block moves a data register value between the core and memory one byte at a time. It uses only every other byte address, so it can talk to an 8-bit peripheral that is wired to one half of a 16-bit bus. A transfer is either 2 bytes (word) or 4 bytes (long). The operand's most significant byte goes to or comes from the lowest address.

The caller presents a transfer opcode word, a 16-bit displacement, the value of the selected address register and the value of the selected data register, then pulses a start strobe. The register index outputs are decoded straight from the opcode in the same cycle, so a register file can return both values before the strobe is sampled. The block then issues one byte request at a time. Each request is held until it is acknowledged. After the last byte it pulses done for one cycle and presents the resulting register value and the nominal cycle cost of the transfer. Fetching the opcode and the displacement is the caller's job.

Top module: `alt_byte_xfer`

## Requirements
- R1: The byte addresses of a transfer are base, base+2, base+4, base+6 in that order. Base is the address register value plus the sign-extended 16-bit displacement.
- R2: On a write to memory, the first byte sent is the operand's most significant byte: bits 15:8 for a word and bits 31:24 for a long. Each later byte is the next lower byte.
- R3: Opcode bit 6 selects the size. A value of 0 moves a word in exactly 2 byte accesses, and a value of 1 moves a long in exactly 4.
- R4: Opcode bit 7 selects the direction. A value of 1 writes the register to memory with `mem_we_o` high on every access. A value of 0 reads memory into the register with `mem_we_o` low.
- R5: `dreg_sel_o` equals opcode bits 11:9 and `areg_sel_o` equals opcode bits 2:0, combinationally.
- R6: Only one byte request is outstanding. Address and write data stay stable until `mem_ack_i`, and the next byte is requested only after that acknowledge.
- R7: `done_o` is high for exactly one cycle, in the cycle after the last acknowledge. No request is active while it is high. `result_o` and `cycles_o` hold their values until the next completion.
- R8: A long read returns the four bytes packed MSB-first. A word read puts the two bytes in bits 15:0 and keeps bits 31:16 of the supplied data register value.
- R9: `cycles_o` reports 16 after a word transfer and 24 after a long transfer.
- R10: A start strobe is accepted only when the block is idle. A strobe during a transfer changes neither the direction, the size, nor the number of bytes of that transfer.
- R11: After a write to memory, `result_o` equals the data register value supplied at start.
- R12: After reset, no request is active, `done_o` is low, and `result_o` and `cycles_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled when idle |
| opcode_i | input | 16 | Transfer opcode word |
| disp_i | input | DISP_W | Signed address displacement |
| areg_val_i | input | ADDR_W | Value of the selected address register |
| dreg_val_i | input | DATA_W | Value of the selected data register |
| dreg_sel_o | output | 3 | Data register index decoded from the opcode |
| areg_sel_o | output | 3 | Address register index decoded from the opcode |
| mem_req_o | output | 1 | Byte request active |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Byte address of the request |
| mem_wdata_o | output | 8 | Write byte |
| mem_ack_i | input | 1 | Request acknowledge |
| mem_rdata_i | input | 8 | Read byte, valid with the acknowledge |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | DATA_W | New data register value |
| cycles_o | output | CYC_W | Nominal cycle cost of the last transfer |

## Verification
The bench builds the block with its default parameters: 32-bit address and data, 16-bit displacement, a stride of 2, and cycle costs of 16 and 24. The 32-bit address lets a negative displacement borrow across the full base and lets a base above 64K show that the high address bits are carried. The 32-bit data register makes it possible to tell a word read that preserves bits 31:16 from a long read that replaces them. The memory model answers with zero to three wait cycles. With that latency a start strobe can land in the middle of a transfer, and hold-until-acknowledge is exercised under back-pressure.

// File: rtl/alt_byte_pkg.sv
package alt_byte_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } xfer_state_t;

  typedef struct packed {
    logic       to_mem;
    logic       is_long;
    logic [2:0] dreg;
    logic [2:0] areg;
  } xfer_fields_t;

  localparam int unsigned DIR_BIT  = 7;
  localparam int unsigned SIZE_BIT = 6;
  localparam int unsigned DREG_LSB = 9;
  localparam int unsigned AREG_LSB = 0;

endpackage

// File: rtl/abx_decode.sv
module abx_decode
  import alt_byte_pkg::*;
(
  input  logic [15:0]  opcode_i,
  output xfer_fields_t fields_o
);
  always_comb begin
    fields_o.to_mem  = opcode_i[DIR_BIT];
    fields_o.is_long = opcode_i[SIZE_BIT];
    fields_o.dreg    = opcode_i[DREG_LSB +: 3];
    fields_o.areg    = opcode_i[AREG_LSB +: 3];
  end
endmodule

// File: rtl/abx_addr_gen.sv
module abx_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 16,
  parameter int unsigned STRIDE = 2,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] areg_val_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] base_q_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] base_d_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;

  assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign base_d_o = areg_val_i + disp_ext;
  assign addr_o   = base_q_i + ADDR_W'(idx_i) * ADDR_W'(STRIDE);
endmodule

// File: rtl/abx_byte_lane.sv
module abx_byte_lane #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              load_long_i,
  input  logic [DATA_W-1:0] dreg_val_i,
  input  logic              shift_i,
  input  logic              to_mem_i,
  input  logic              is_long_i,
  input  logic [7:0]        rdata_i,
  output logic [7:0]        wdata_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int unsigned HALF = DATA_W / 2;

  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] orig_q;
  logic [DATA_W-1:0] sh_next;

  // the byte arriving with the ack is folded in so the result is ready at the ack edge
  assign sh_next = {sh_q[DATA_W-9:0], rdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      orig_q <= '0;
    end else if (load_i) begin
      sh_q   <= load_long_i ? dreg_val_i : {dreg_val_i[HALF-1:0], {HALF{1'b0}}};
      orig_q <= dreg_val_i;
    end else if (shift_i) begin
      sh_q   <= sh_next;
    end
  end

  assign wdata_o = sh_q[DATA_W-1 -: 8];

  always_comb begin
    if (to_mem_i)       result_o = orig_q;
    else if (is_long_i) result_o = sh_next;
    else                result_o = {orig_q[DATA_W-1:HALF], sh_next[HALF-1:0]};
  end
endmodule

// File: rtl/alt_byte_xfer.sv
module alt_byte_xfer
  import alt_byte_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned DISP_W      = 16,
  parameter int unsigned STRIDE      = 2,
  parameter int unsigned CYC_W       = 8,
  parameter int unsigned WORD_CYCLES = 16,
  parameter int unsigned LONG_CYCLES = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [15:0]       opcode_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] areg_val_i,
  input  logic [DATA_W-1:0] dreg_val_i,
  output logic [2:0]        dreg_sel_o,
  output logic [2:0]        areg_sel_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o,
  output logic [CYC_W-1:0]  cycles_o
);
  localparam int unsigned NB_LONG = DATA_W / 8;
  localparam int unsigned NB_WORD = NB_LONG / 2;
  localparam int unsigned IDX_W   = $clog2(NB_LONG);
  localparam logic [IDX_W-1:0] LAST_LONG = IDX_W'(NB_LONG - 1);
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(NB_WORD - 1);

  xfer_state_t       state_q;
  xfer_fields_t      fields;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_d;
  logic              long_q;
  logic              to_mem_q;
  logic [DATA_W-1:0] result_q;
  logic [CYC_W-1:0]  cycles_q;
  logic [DATA_W-1:0] lane_result;
  logic              accept;
  logic              step;
  logic              last;

  abx_decode u_decode (
    .opcode_i (opcode_i),
    .fields_o (fields)
  );

  assign dreg_sel_o = fields.dreg;
  assign areg_sel_o = fields.areg;

  abx_addr_gen #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .STRIDE (STRIDE),
    .IDX_W  (IDX_W)
  ) u_addr (
    .areg_val_i (areg_val_i),
    .disp_i     (disp_i),
    .base_q_i   (base_q),
    .idx_i      (idx_q),
    .base_d_o   (base_d),
    .addr_o     (mem_addr_o)
  );

  assign accept = (state_q == ST_IDLE) && start_i;
  assign step   = (state_q == ST_XFER) && mem_ack_i;
  assign last   = idx_q == (long_q ? LAST_LONG : LAST_WORD);

  abx_byte_lane #(
    .DATA_W (DATA_W)
  ) u_lane (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .load_long_i (fields.is_long),
    .dreg_val_i  (dreg_val_i),
    .shift_i     (step),
    .to_mem_i    (to_mem_q),
    .is_long_i   (long_q),
    .rdata_i     (mem_rdata_i),
    .wdata_o     (mem_wdata_o),
    .result_o    (lane_result)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      base_q   <= '0;
      long_q   <= 1'b0;
      to_mem_q <= 1'b0;
      result_q <= '0;
      cycles_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          base_q   <= base_d;
          long_q   <= fields.is_long;
          to_mem_q <= fields.to_mem;
          idx_q    <= '0;
          state_q  <= ST_XFER;
        end
        ST_XFER: if (mem_ack_i) begin
          if (last) begin
            result_q <= lane_result;
            cycles_q <= long_q ? CYC_W'(LONG_CYCLES) : CYC_W'(WORD_CYCLES);
            state_q  <= ST_DONE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o = state_q == ST_XFER;
  assign mem_we_o  = mem_req_o && to_mem_q;
  assign done_o    = state_q == ST_DONE;
  assign result_o  = result_q;
  assign cycles_o  = cycles_q;

  p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o));

  p_stride_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && !last |=> mem_req_o && (mem_addr_o == $past(mem_addr_o) + ADDR_W'(STRIDE)));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_no_req_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);

  p_done_follows_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_req_o) |-> done_o);

  p_busy_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i && start_i |=> $stable(mem_we_o));

  p_result_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o && !$past(mem_req_o) |-> $stable(result_o) && $stable(cycles_o));

  p_cycles_legal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cycles_o == CYC_W'(WORD_CYCLES)) || (cycles_o == CYC_W'(LONG_CYCLES)));
endmodule

// File: tb/alt_byte_xfer_tb_top.sv
`timescale 1ns/1ps
module alt_byte_xfer_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] opcode_i = '0;
  logic [15:0] disp_i = '0;
  logic [31:0] areg_val_i = '0;
  logic [31:0] dreg_val_i = '0;
  logic [2:0]  dreg_sel_o, areg_sel_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [7:0]  mem_rdata_i = '0;
  logic        done_o;
  logic [31:0] result_o;
  logic [7:0]  cycles_o;

  always #2 clk_i = ~clk_i;

  alt_byte_xfer dut_i (
    .clk_i, .rst_ni, .start_i, .opcode_i, .disp_i, .areg_val_i, .dreg_val_i,
    .dreg_sel_o, .areg_sel_o, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_ack_i, .mem_rdata_i, .done_o, .result_o, .cycles_o
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [7:0]  mem [256];
  logic [31:0] addr_log [8];
  logic        we_log   [8];
  logic [7:0]  wd_log   [8];
  int          log_n = 0;
  int          lat = 0;
  int          wait_cnt = 0;

  // op, disp, areg, dreg, expected result
  localparam logic [127:0] VEC [5] = '{
    {16'h070A, 16'h0004, 32'h1000_0010, 32'hDEAD_BEEF, 32'hDEAD_1416},
    {16'h014D, 16'hFFF0, 32'h0000_0020, 32'h0000_0000, 32'h1012_1416},
    {16'h0388, 16'h0000, 32'h0000_0080, 32'h1234_5678, 32'h1234_5678},
    {16'h0FCF, 16'h0010, 32'h0000_00C0, 32'hCAFE_BABE, 32'hCAFE_BABE},
    {16'h0549, 16'h0002, 32'h0000_007E, 32'hFFFF_FFFF, 32'h5678_8486}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // memory responder, acts away from the active edge
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    forever begin
      @(negedge clk_i);
      if (mem_ack_i) begin
        mem_ack_i = 1'b0;
      end else if (mem_req_o) begin
        if (wait_cnt < lat) begin
          wait_cnt++;
        end else begin
          wait_cnt = 0;
          if (log_n < 8) begin
            addr_log[log_n] = mem_addr_o;
            we_log[log_n]   = mem_we_o;
            wd_log[log_n]   = mem_wdata_o;
          end
          log_n++;
          if (mem_we_o) mem[mem_addr_o[7:0]] = mem_wdata_o;
          else          mem_rdata_i = mem[mem_addr_o[7:0]];
          mem_ack_i = 1'b1;
        end
      end
    end
  end

  task automatic start_xfer(input logic [15:0] op, input logic [15:0] d,
                            input logic [31:0] a, input logic [31:0] r);
    @(negedge clk_i);
    opcode_i = op; disp_i = d; areg_val_i = a; dreg_val_i = r;
    log_n = 0;
    #1;
    chk("R5 dreg_sel", 32'(dreg_sel_o), 32'(op[11:9]));
    chk("R5 areg_sel", 32'(areg_sel_o), 32'(op[2:0]));
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done_o && guard < 200) begin
      @(negedge clk_i);
      guard++;
    end
    chk("R7 done seen", 32'(done_o), 32'd1);
    chk("R7 no req with done", 32'(mem_req_o), 32'd0);
  endtask

  task automatic check_xfer(input logic [15:0] op, input logic [15:0] d,
                            input logic [31:0] a, input logic [31:0] r,
                            input logic [31:0] exp_res);
    logic        lng;
    logic        wr;
    int          nb;
    logic [31:0] base;
    lng  = op[6];
    wr   = op[7];
    nb   = lng ? 4 : 2;
    base = a + {{16{d[15]}}, d};
    chk("R3 byte count", 32'(log_n), 32'(nb));
    for (int k = 0; k < nb && k < 8; k++) begin
      chk("R1 address", addr_log[k], base + 32'(2 * k));
      chk("R4 direction", 32'(we_log[k]), 32'(wr));
      if (wr) chk("R2 write byte", 32'(wd_log[k]), 32'(r[(lng ? 31 : 15) - 8 * k -: 8]));
    end
    if (wr) chk("R11 write result", result_o, exp_res);
    else    chk("R8 read result", result_o, exp_res);
    chk("R9 cycles", 32'(cycles_o), lng ? 32'd24 : 32'd16);
    @(negedge clk_i);
    chk("R7 done one cycle", 32'(done_o), 32'd0);
    chk("R7 result held", result_o, exp_res);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R12 req after reset", 32'(mem_req_o), 32'd0);
    chk("R12 done after reset", 32'(done_o), 32'd0);
    chk("R12 result after reset", result_o, 32'd0);
    chk("R12 cycles after reset", 32'(cycles_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int v = 0; v < 5; v++) begin
      lat = v % 4;
      start_xfer(VEC[v][127:112], VEC[v][111:96], VEC[v][95:64], VEC[v][63:32]);
      wait_done();
      check_xfer(VEC[v][127:112], VEC[v][111:96], VEC[v][95:64], VEC[v][63:32], VEC[v][31:0]);
    end

    // R2: memory image after the word and long writes
    chk("R2 mem 0x80", 32'(mem[8'h80]), 32'h56);
    chk("R2 mem 0x82", 32'(mem[8'h82]), 32'h78);
    chk("R1 odd byte untouched", 32'(mem[8'h81]), 32'h81);
    chk("R2 mem 0xD0", 32'(mem[8'hD0]), 32'hCA);
    chk("R2 mem 0xD6", 32'(mem[8'hD6]), 32'hBE);

    // R10: start strobe with a long write opcode during a word read
    lat = 3;
    start_xfer(16'h070A, 16'h0000, 32'h0000_0040, 32'hAAAA_5555);
    while (!mem_req_o) @(negedge clk_i);
    opcode_i = 16'h0FCF;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done();
    check_xfer(16'h070A, 16'h0000, 32'h0000_0040, 32'hAAAA_5555, 32'hAAAA_4042);
    chk("R10 no new transfer", 32'(mem_req_o), 32'd0);
    repeat (4) @(negedge clk_i);
    chk("R10 stays idle", 32'(mem_req_o), 32'd0);

    // R8: zero-latency long read across a base above 64K
    lat = 0;
    start_xfer(16'h014D, 16'h8000, 32'h0001_8020, 32'h1111_1111);
    wait_done();
    check_xfer(16'h014D, 16'h8000, 32'h0001_8020, 32'h1111_1111, 32'h2022_2426);

    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      summary();
    end
  end

endmodule